// File: doc/BRIEF.md
# Bus-master DMA channel register file

This block is the host-facing register set of one bus-master disk DMA channel. Software reaches it through an eight-byte I/O window with a simple port. The port does byte reads and writes anywhere in the window, plus dword access to the descriptor pointer. The block holds the channel's command settings, a status byte, two vendor scratch bytes and the physical address of the descriptor table. It presents the go, direction and table address to a separate transfer engine, which is not part of this block.

The status byte gathers three kinds of bit:
- An activity flag that only hardware changes.
- Error and interrupt flags that hardware sets and software clears by writing ones.
- Per-drive DMA-capable flags that software reads and writes freely.

The usual driver flow is: program the pointer and direction, issue the disk command, set the go bit, wait for the drive interrupt, clear the go bit, then judge the result from the low three status bits.

Top module: `bm_dma_regs`

## Requirements
- R1: Reset (active-low, asynchronous) clears every register. Every byte and dword read returns zero, and `eng_start_o`, `eng_dir_o` and `eng_tbl_ptr_o` are zero.
- R2: The window layout is fixed. Offset 0 is command, 1 is vendor byte A, 2 is status, 3 is vendor byte B, and 4 to 7 are the pointer bytes (offset 4 least significant). A byte read returns the value zero-extended in `rdata_o[7:0]`. A dword access at offset 4 reaches the whole pointer. A dword access at any other offset reads zero, and a dword write there has no effect.
- R3: Command bit 0 is go and command bit 3 is direction (1 = device to memory). The other command bits read 0. `eng_start_o` and `eng_dir_o` follow the stored bits one cycle after the write.
- R4: The pointer's low ALIGN_BITS bits always read 0, and `eng_tbl_ptr_o` equals the readable pointer value.
- R5: Status bit 0 (active) is set by a command write with bit 0 = 1 while go is 0. It is cleared by a command write with bit 0 = 0, by `eng_done_i`, or by `eng_err_i` while active. Writes to status bit 0 have no effect.
- R6: Status bit 1 (error) is set by `eng_err_i` while active. An error pulse while inactive is ignored.
- R7: Status bit 2 (interrupt) is set on a rising edge of `drv_irq_i`. A level held high does not set it again after it has been cleared.
- R8: Writing 1 to status bit 1 or 2 clears that bit, and writing 0 leaves it unchanged. A set event in the same cycle as the clear wins.
- R9: Status bits 5 and 6 are read/write DMA-capable flags for drive 0 and drive 1. Status bits 3, 4 and 7 read 0.
- R10: A clean transfer leaves status bits 2:0 at 3'b100 after go is cleared: interrupt seen, no error, not active.
- R11: A command write with bit 0 = 1 while go is already 1 does not re-arm the active bit. A new transfer needs go cleared first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Bus access valid this cycle |
| wr_i | input | 1 | 1 = write, 0 = read |
| dw_i | input | 1 | 1 = dword access, 0 = byte access |
| addr_i | input | 3 | Byte offset in the window |
| wdata_i | input | 32 | Write data (byte in bits 7:0) |
| rdata_o | output | 32 | Read data, combinational |
| eng_start_o | output | 1 | Go bit to the transfer engine |
| eng_dir_o | output | 1 | 1 = device to memory |
| eng_tbl_ptr_o | output | 32 | Descriptor table address |
| eng_done_i | input | 1 | Engine reached end of table (pulse) |
| eng_err_i | input | 1 | Engine error (pulse) |
| drv_irq_i | input | 1 | Drive interrupt level |

## Verification
The bench uses the default parameters: two drives and two alignment bits. With these values both capability flags and the partially writable low pointer byte can be exercised, as can the masking of bits 1:0 on byte and dword writes. Directed sequences target the status corners:
- an interrupt level held across a clear;
- an error pulse while idle;
- a go rewrite after completion;
- an interrupt edge that lands in the same cycle as a write-one clear.

// File: rtl/bm_dma_pkg.sv
package bm_dma_pkg;
  localparam int unsigned WIN_AW  = 3;
  localparam int unsigned BUS_W   = 32;
  localparam int unsigned N_LANES = BUS_W / 8;

  localparam logic [WIN_AW-1:0] OFF_CMD   = 3'd0;
  localparam logic [WIN_AW-1:0] OFF_VND_A = 3'd1;
  localparam logic [WIN_AW-1:0] OFF_STAT  = 3'd2;
  localparam logic [WIN_AW-1:0] OFF_VND_B = 3'd3;
  localparam logic [WIN_AW-1:0] OFF_PTR   = 3'd4;

  localparam int unsigned CMD_GO  = 0;
  localparam int unsigned CMD_DIR = 3;
  localparam int unsigned ST_ACT  = 0;
  localparam int unsigned ST_ERR  = 1;
  localparam int unsigned ST_IRQ  = 2;

  typedef struct packed {
    logic               cmd;
    logic               stat;
    logic [1:0]         vnd;
    logic [N_LANES-1:0] ptr_lane;
  } wr_sel_t;
endpackage

// File: rtl/bm_dma_decode.sv
module bm_dma_decode
  import bm_dma_pkg::*;
(
  input  logic              req_i,
  input  logic              wr_i,
  input  logic              dw_i,
  input  logic [WIN_AW-1:0] addr_i,
  output wr_sel_t           sel_o
);
  always_comb begin
    sel_o = '0;
    if (req_i && wr_i) begin
      if (dw_i) begin
        if (addr_i == OFF_PTR) sel_o.ptr_lane = '1;
      end else begin
        unique case (addr_i)
          OFF_CMD:   sel_o.cmd    = 1'b1;
          OFF_VND_A: sel_o.vnd[0] = 1'b1;
          OFF_STAT:  sel_o.stat   = 1'b1;
          OFF_VND_B: sel_o.vnd[1] = 1'b1;
          default:   sel_o.ptr_lane[addr_i[1:0]] = 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/bm_dma_cmd.sv
module bm_dma_cmd (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic we_i,
  input  logic go_i,
  input  logic dir_i,
  output logic go_o,
  output logic dir_o,
  output logic go_rise_o,
  output logic go_stop_o
);
  assign go_rise_o = we_i & go_i & ~go_o;
  assign go_stop_o = we_i & ~go_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      go_o  <= 1'b0;
      dir_o <= 1'b0;
    end else if (we_i) begin
      go_o  <= go_i;
      dir_o <= dir_i;
    end
  end
endmodule

// File: rtl/bm_dma_status.sv
module bm_dma_status #(
  parameter int unsigned N_DRIVES = 2,
  parameter int unsigned CAP_LSB  = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic                clr_err_i,
  input  logic                clr_irq_i,
  input  logic [N_DRIVES-1:0] cap_i,
  input  logic                go_rise_i,
  input  logic                go_stop_i,
  input  logic                eng_done_i,
  input  logic                eng_err_i,
  input  logic                drv_irq_i,
  output logic                act_o,
  output logic                err_o,
  output logic                irq_o,
  output logic [7:0]          stat_o
);
  import bm_dma_pkg::*;

  logic                irq_q;
  logic                irq_edge;
  logic                err_set;
  logic [N_DRIVES-1:0] cap_q;

  assign irq_edge = drv_irq_i & ~irq_q;
  assign err_set  = eng_err_i & act_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_o <= 1'b0;
      err_o <= 1'b0;
      irq_o <= 1'b0;
      irq_q <= 1'b0;
      cap_q <= '0;
    end else begin
      irq_q <= drv_irq_i;
      if (go_stop_i)                      act_o <= 1'b0;
      else if (go_rise_i)                 act_o <= 1'b1;
      else if (act_o && (eng_done_i || eng_err_i)) act_o <= 1'b0;
      // set beats write-one clear in the same cycle
      err_o <= (err_o & ~(we_i & clr_err_i)) | err_set;
      irq_o <= (irq_o & ~(we_i & clr_irq_i)) | irq_edge;
      if (we_i) cap_q <= cap_i;
    end
  end

  always_comb begin
    stat_o                      = '0;
    stat_o[ST_ACT]              = act_o;
    stat_o[ST_ERR]              = err_o;
    stat_o[ST_IRQ]              = irq_o;
    stat_o[CAP_LSB +: N_DRIVES] = cap_q;
  end
endmodule

// File: rtl/bm_dma_ptr.sv
module bm_dma_ptr #(
  parameter int unsigned ALIGN_BITS = 2
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic [bm_dma_pkg::N_LANES-1:0]    lane_we_i,
  input  logic [bm_dma_pkg::BUS_W-1:0]      wdata_i,
  input  logic [bm_dma_pkg::WIN_AW-1:0]     addr_i,
  input  logic                              dw_i,
  output logic [bm_dma_pkg::BUS_W-1:0]      ptr_o
);
  import bm_dma_pkg::*;
  localparam logic [BUS_W-1:0] KEEP = ~((BUS_W'(1) << ALIGN_BITS) - BUS_W'(1));

  logic [BUS_W-1:0] ptr_q;
  logic [BUS_W-1:0] ptr_d;

  // byte writes carry data in lane 0 of the bus, dword writes in place
  for (genvar l = 0; l < N_LANES; l++) begin : g_lane
    logic [7:0] src;
    assign src = dw_i ? wdata_i[8*l +: 8] : wdata_i[7:0];
    assign ptr_d[8*l +: 8] = lane_we_i[l] ? src : ptr_q[8*l +: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (|lane_we_i) ptr_q <= ptr_d & KEEP;
  end

  assign ptr_o = ptr_q;

  logic unused_addr;
  assign unused_addr = ^addr_i;
endmodule

// File: rtl/bm_dma_regs.sv
module bm_dma_regs
  import bm_dma_pkg::*;
#(
  parameter int unsigned N_DRIVES   = 2,
  parameter int unsigned CAP_LSB    = 5,
  parameter int unsigned ALIGN_BITS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic              dw_i,
  input  logic [2:0]        addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              eng_start_o,
  output logic              eng_dir_o,
  output logic [31:0]       eng_tbl_ptr_o,
  input  logic              eng_done_i,
  input  logic              eng_err_i,
  input  logic              drv_irq_i
);
  wr_sel_t    sel;
  logic       go_rise, go_stop;
  logic       act_w, err_w, irq_w;
  logic [7:0] stat_w;
  logic [7:0] cmd_w;
  logic [7:0] vnd_q [2];

  bm_dma_decode u_dec (
    .req_i (req_i), .wr_i (wr_i), .dw_i (dw_i), .addr_i (addr_i), .sel_o (sel)
  );

  bm_dma_cmd u_cmd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (sel.cmd),
    .go_i      (wdata_i[CMD_GO]),
    .dir_i     (wdata_i[CMD_DIR]),
    .go_o      (eng_start_o),
    .dir_o     (eng_dir_o),
    .go_rise_o (go_rise),
    .go_stop_o (go_stop)
  );

  bm_dma_status #(.N_DRIVES(N_DRIVES), .CAP_LSB(CAP_LSB)) u_stat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (sel.stat),
    .clr_err_i  (wdata_i[ST_ERR]),
    .clr_irq_i  (wdata_i[ST_IRQ]),
    .cap_i      (wdata_i[CAP_LSB +: N_DRIVES]),
    .go_rise_i  (go_rise),
    .go_stop_i  (go_stop),
    .eng_done_i (eng_done_i),
    .eng_err_i  (eng_err_i),
    .drv_irq_i  (drv_irq_i),
    .act_o      (act_w),
    .err_o      (err_w),
    .irq_o      (irq_w),
    .stat_o     (stat_w)
  );

  bm_dma_ptr #(.ALIGN_BITS(ALIGN_BITS)) u_ptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lane_we_i (sel.ptr_lane),
    .wdata_i   (wdata_i),
    .addr_i    (addr_i),
    .dw_i      (dw_i),
    .ptr_o     (eng_tbl_ptr_o)
  );

  for (genvar v = 0; v < 2; v++) begin : g_vnd
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) vnd_q[v] <= '0;
      else if (sel.vnd[v]) vnd_q[v] <= wdata_i[7:0];
    end
  end

  always_comb begin
    cmd_w          = '0;
    cmd_w[CMD_GO]  = eng_start_o;
    cmd_w[CMD_DIR] = eng_dir_o;
  end

  always_comb begin
    rdata_o = '0;
    if (dw_i) begin
      if (addr_i == OFF_PTR) rdata_o = eng_tbl_ptr_o;
    end else begin
      unique case (addr_i)
        OFF_CMD:   rdata_o[7:0] = cmd_w;
        OFF_VND_A: rdata_o[7:0] = vnd_q[0];
        OFF_STAT:  rdata_o[7:0] = stat_w;
        OFF_VND_B: rdata_o[7:0] = vnd_q[1];
        default:   rdata_o[7:0] = eng_tbl_ptr_o[8*addr_i[1:0] +: 8];
      endcase
    end
  end
endmodule

// File: rtl/bm_dma_regs_chk.sv
module bm_dma_regs_chk #(
  parameter int unsigned ALIGN_BITS = 2
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_i,
  input logic        wr_i,
  input logic        dw_i,
  input logic [2:0]  addr_i,
  input logic [31:0] wdata_i,
  input logic        eng_start_o,
  input logic [31:0] eng_tbl_ptr_o,
  input logic        eng_err_i,
  input logic        drv_irq_i,
  input logic        act_w,
  input logic        err_w,
  input logic        irq_w
);
  localparam logic [31:0] KEEP = ~((32'd1 << ALIGN_BITS) - 32'd1);

  logic irq_prev;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_prev <= 1'b0;
    else         irq_prev <= drv_irq_i;
  end

  logic cmd_wr, stat_wr, ptr_dw_wr;
  assign cmd_wr    = req_i && wr_i && !dw_i && addr_i == 3'd0;
  assign stat_wr   = req_i && wr_i && !dw_i && addr_i == 3'd2;
  assign ptr_dw_wr = req_i && wr_i && dw_i && addr_i == 3'd4;

  // R5
  go_sets_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && wdata_i[0] && !eng_start_o) |=> act_w);
  // R5
  stop_clears_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && !wdata_i[0]) |=> (!act_w && !eng_start_o));
  // R3
  active_needs_go_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_w |-> eng_start_o);
  // R6
  err_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_err_i && act_w) |=> err_w);
  // R7
  irq_edge_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drv_irq_i && !irq_prev) |=> irq_w);
  // R8
  irq_w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_wr && wdata_i[2] && !(drv_irq_i && !irq_prev)) |=> !irq_w);
  // R4
  ptr_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_dw_wr |=> (eng_tbl_ptr_o == ($past(wdata_i) & KEEP)));
endmodule

bind bm_dma_regs bm_dma_regs_chk #(.ALIGN_BITS(ALIGN_BITS)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_i         (req_i),
  .wr_i          (wr_i),
  .dw_i          (dw_i),
  .addr_i        (addr_i),
  .wdata_i       (wdata_i),
  .eng_start_o   (eng_start_o),
  .eng_tbl_ptr_o (eng_tbl_ptr_o),
  .eng_err_i     (eng_err_i),
  .drv_irq_i     (drv_irq_i),
  .act_w         (act_w),
  .err_w         (err_w),
  .irq_w         (irq_w)
);

// File: tb/tb_bm_dma_regs.sv
module tb_bm_dma_regs;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0, wr = 1'b0, dw = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        go, dir;
  logic [31:0] tptr;
  logic        done_p = 1'b0, err_p = 1'b0, irq = 1'b0;

  int checks = 0, failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  bm_dma_regs dut (
    .clk_i (clk), .rst_ni (rst_ni), .req_i (req), .wr_i (wr), .dw_i (dw),
    .addr_i (addr), .wdata_i (wdata), .rdata_o (rdata),
    .eng_start_o (go), .eng_dir_o (dir), .eng_tbl_ptr_o (tptr),
    .eng_done_i (done_p), .eng_err_i (err_p), .drv_irq_i (irq)
  );

  // {tag, wr, dw, addr, wdata, expected}
  localparam int NV = 29;
  localparam logic [79:0] VEC [NV] = '{
    80'h1_0_0_0_00000000_00000000, // R1 cmd
    80'h1_0_0_2_00000000_00000000, // R1 status
    80'h1_0_1_4_00000000_00000000, // R1 pointer
    80'h4_1_1_4_12345677_00000000, // R4
    80'h4_0_1_4_00000000_12345674, // R4 low bits zero
    80'h2_1_0_5_000000AB_00000000, // R2 lane 1
    80'h2_0_1_4_00000000_1234AB74, // R2
    80'h2_0_0_7_00000000_00000012, // R2 top lane
    80'h2_1_0_1_0000005A_00000000, // R2 vendor A
    80'h2_0_0_1_00000000_0000005A,
    80'h2_1_0_3_000000C3_00000000, // R2 vendor B
    80'h2_0_0_3_00000000_000000C3,
    80'h2_0_0_1_00000000_0000005A,
    80'h3_1_0_0_000000FF_00000000, // R3
    80'h3_0_0_0_00000000_00000009, // R3 reserved bits zero
    80'h5_0_0_2_00000000_00000001, // R5 active
    80'h5_1_0_2_00000000_00000000, // R5 bit0 write ignored
    80'h5_0_0_2_00000000_00000001,
    80'h5_1_0_0_00000008_00000000, // R5 stop
    80'h5_0_0_2_00000000_00000000,
    80'h3_0_0_0_00000000_00000008, // R3
    80'h9_1_0_2_000000FF_00000000, // R9
    80'h9_0_0_2_00000000_00000060,
    80'h9_1_0_2_00000020_00000000, // R9
    80'h9_0_0_2_00000000_00000020,
    80'h2_0_1_0_00000000_00000000, // R2 dword off pointer
    80'h2_1_1_0_FFFFFFFF_00000000, // R2 ignored
    80'h2_0_0_0_00000000_00000008,
    80'h2_0_0_2_00000000_00000020
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic d, input logic [2:0] a, input logic [31:0] v);
    @(negedge clk);
    req = 1'b1; wr = 1'b1; dw = d; addr = a; wdata = v;
    @(negedge clk);
    req = 1'b0; wr = 1'b0; dw = 1'b0; wdata = '0;
  endtask

  task automatic bus_rd(input logic d, input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    dw = d; addr = a;
    #2 v = rdata;
    dw = 1'b0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) done_p = 1'b1; else err_p = 1'b1;
    @(negedge clk);
    done_p = 1'b0; err_p = 1'b0;
  endtask

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R1 engine outputs after reset
    @(negedge clk);
    chk("R1 outputs", {go, dir, tptr[29:0]}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [79:0] v;
      string t;
      v = VEC[i];
      t = $sformatf("R%0d vec%0d", v[79:76], i);
      if (v[72]) bus_wr(v[68], v[66:64], v[63:32]);
      else begin
        bus_rd(v[68], v[66:64], r);
        chk(t, r, v[31:0]);
      end
    end

    // R3 R4 engine side mirrors registers
    chk("R3 outputs", {30'h0, go, dir}, 32'h1);
    chk("R4 pointer out", tptr, 32'h1234AB74);

    // R10 clean transfer
    bus_wr(1'b0, 3'd0, 32'h09);
    bus_rd(1'b0, 3'd2, r); chk("R5 armed", r, 32'h21);
    @(negedge clk); irq = 1'b1;
    pulse(0);
    bus_rd(1'b0, 3'd2, r); chk("R7 R5 done+irq", r, 32'h24);
    chk("R3 go held", {31'h0, go}, 32'h1);
    bus_wr(1'b0, 3'd0, 32'h08);
    bus_rd(1'b0, 3'd2, r); chk("R10 clean pattern", {29'h0, r[2:0]}, 32'h4);

    // R7 R8 level held high does not re-set after clear
    bus_wr(1'b0, 3'd2, 32'h24);
    bus_rd(1'b0, 3'd2, r); chk("R8 R7 cleared under level", r, 32'h20);
    @(negedge clk); irq = 1'b0;
    @(negedge clk); irq = 1'b1;
    @(negedge clk);
    bus_rd(1'b0, 3'd2, r); chk("R7 new edge", r, 32'h24);
    bus_wr(1'b0, 3'd2, 32'h20);
    bus_rd(1'b0, 3'd2, r); chk("R8 write zero keeps", r, 32'h24);
    bus_wr(1'b0, 3'd2, 32'h26);
    bus_rd(1'b0, 3'd2, r); chk("R8 clear", r, 32'h20);

    // R6 error while idle ignored, then during transfer
    pulse(1);
    bus_rd(1'b0, 3'd2, r); chk("R6 idle error ignored", r, 32'h20);
    bus_wr(1'b0, 3'd0, 32'h01);
    chk("R3 dir write", {31'h0, dir}, 32'h0);
    bus_rd(1'b0, 3'd2, r); chk("R5 armed again", r, 32'h21);
    pulse(1);
    bus_rd(1'b0, 3'd2, r); chk("R6 error sets, R5 ends", r, 32'h22);

    // R11 no re-arm while go stays 1
    bus_wr(1'b0, 3'd0, 32'h01);
    bus_rd(1'b0, 3'd2, r); chk("R11 no re-arm", r, 32'h22);
    bus_wr(1'b0, 3'd0, 32'h00);
    bus_wr(1'b0, 3'd0, 32'h01);
    bus_rd(1'b0, 3'd2, r); chk("R11 re-arm after stop", r, 32'h23);
    bus_wr(1'b0, 3'd0, 32'h00);
    bus_wr(1'b0, 3'd2, 32'h22);
    bus_rd(1'b0, 3'd2, r); chk("R8 error cleared", r, 32'h20);

    // R8 set wins over clear in same cycle
    @(negedge clk); irq = 1'b0;
    @(negedge clk);
    irq = 1'b1; req = 1'b1; wr = 1'b1; dw = 1'b0; addr = 3'd2; wdata = 32'h24;
    @(negedge clk);
    req = 1'b0; wr = 1'b0; wdata = '0;
    bus_rd(1'b0, 3'd2, r); chk("R8 set wins", r, 32'h24);

    // R1 asynchronous reset mid-run
    bus_wr(1'b0, 3'd0, 32'h09);
    @(negedge clk); #3 rst_ni = 1'b0;
    #2;
    chk("R1 async outputs", {go, dir, tptr[29:0]}, 32'h0);
    bus_rd(1'b0, 3'd2, r); chk("R1 async status", r, 32'h0);
    bus_rd(1'b0, 3'd1, r); chk("R1 async vendor", r, 32'h0);
    bus_rd(1'b0, 3'd0, r); chk("R1 async cmd", r, 32'h0);
    rst_ni = 1'b1;

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule